// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block decides which of several DMA channels may use a single shared system bus. It raises a bus request toward an external bus arbiter whenever any channel has work. It chooses a channel only once the grant arrives, taking the highest-ranked request present in that cycle, and reports the owner on a one-hot `active` output. It does not generate addresses, move data or count transfers. The channel logic reports progress through a per-unit strobe `unit_done` and an end-of-burst or end-of-block strobe `last_unit`.

The block has two configurations, set by `dual_mode`:
- **Four lanes (`dual_mode` = 0):** independent lanes rank 0A, 0B, 1A, 1B, mapped to `chan_req` bits 0, 1, 2, 3. Bit 0 ranks highest.
- **Two lanes (`dual_mode` = 1):** the odd bits drop out. Bit 0 (channel 0) outranks bit 2 (channel 1).

A per-lane `xfer_hold` bit marks a burst or block transfer, which keeps the bus across units. Without it, the bus is handed back after every unit. A held transfer is cut at a unit boundary when a higher-ranked lane asks for the bus or when another bus master does. Every hand-back drops `bus_req` for at least one cycle. All control pins are plain levels or strobes; there is no data stream and so no back-pressure.

Top module: `dma_chan_arbiter`

## Requirements
- R1: During and right after synchronous reset, `bus_req` is 0 and `active` is all zeros.
- R2: An eligible request seen on a clock edge while the block is idle makes `bus_req` read 1 after that edge.
- R3: In four-lane mode the owner is the lowest-numbered `chan_req` bit set on the edge where `bus_grant` is first seen high, so bit 0 beats 1, 1 beats 2 and 2 beats 3. `active` shows the owner after that edge.
- R4: In two-lane mode, `chan_req` bits 1 and 3 are ignored: on their own they raise no `bus_req`, and they never win. Bit 0 beats bit 2.
- R5: `active` is all zeros whenever `bus_grant` is 0, and it never has more than one bit set.
- R6: While a lane owns the bus, new requests on other lanes do not change `active` between units.
- R7: In four-lane mode, each `unit_done` hands the bus back whatever `xfer_hold` says. After that edge, `bus_req` is 0 and `active` is zero.
- R8: In two-lane mode, an owner whose `xfer_hold` bit is 0 hands the bus back after each `unit_done`.
- R9: In two-lane mode, an owner whose `xfer_hold` bit is 1 keeps the bus on `unit_done` without `last_unit`. It hands the bus back on `unit_done` with `last_unit`.
- R10: During a held transfer, `unit_done` while a higher-ranked eligible lane is requesting hands the bus back, and that lane wins the next grant. A lower-ranked request does not cut the transfer.
- R11: During a held transfer, `unit_done` with `ext_master_req` high hands the bus back.
- R12: After a hand-back, `bus_req` stays 0 for exactly one cycle. It rises again if any eligible request is still present, and stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = two combined lanes, 0 = four independent lanes |
| chan_req | input | NCH | Per-lane transfer request, bit 0 ranked highest |
| xfer_hold | input | NCH | Per-lane burst/block marker, used in two-lane mode only |
| bus_req | output | 1 | Request for the shared bus toward the external arbiter |
| bus_grant | input | 1 | Bus granted by the external arbiter |
| ext_master_req | input | 1 | A higher-ranked bus master wants the bus |
| unit_done | input | 1 | Strobe: the current byte or word has completed |
| last_unit | input | 1 | Qualifies `unit_done`: final unit of the burst or block |
| active | output | NCH | One-hot owner lane, zero when no lane owns the bus |

## Verification
The properties assume that the external arbiter raises `bus_grant` only while `bus_req` is high and holds it until the hand-back. They also assume that `unit_done` pulses only while `active` is nonzero, and that `dual_mode` changes only while the bus is idle. The stimulus meets these assumptions in three ways. It grants only after sampling `bus_req` high, and drops the grant in the cycle after a hand-back. It pulses `unit_done` only between a grant and a hand-back. It switches mode only after `bus_req` has settled low with no request present.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } arb_state_t;
endpackage

// File: rtl/dma_req_mask.sv
// Filters raw requests by configuration and resolves which lanes hold the bus.
module dma_req_mask #(
  parameter int NCH = 4
) (
  input  logic           dual_mode,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] xfer_hold,
  output logic [NCH-1:0] elig,
  output logic [NCH-1:0] hold_eff
);
  for (genvar i = 0; i < NCH; i++) begin : g_lane
    if ((i % 2) == 1) begin : g_b_side
      // B-side lanes only take part when the lanes are not paired.
      assign elig[i] = chan_req[i] & ~dual_mode;
    end else begin : g_a_side
      assign elig[i] = chan_req[i];
    end
    // Holding the bus across units exists only in the paired configuration.
    assign hold_eff[i] = xfer_hold[i] & dual_mode;
  end
endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-rank picker: lowest index wins. Also flags a request that outranks the owner.
module dma_prio_pick #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] elig,
  input  logic [NCH-1:0] owner,
  output logic [NCH-1:0] pick,
  output logic           any_elig,
  output logic           higher_pend
);
  logic [NCH-1:0] above_owner;

  for (genvar i = 0; i < NCH; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign pick[i] = elig[i];
    end else begin : g_rest
      assign pick[i] = elig[i] & ~(|elig[i-1:0]);
    end
    if (i == NCH - 1) begin : g_last
      assign above_owner[i] = 1'b0;
    end else begin : g_mid
      // Lane i outranks the owner when the owner sits at a higher index.
      assign above_owner[i] = |owner[NCH-1:i+1];
    end
  end

  assign any_elig    = |elig;
  assign higher_pend = |(elig & above_owner);
endmodule

// File: rtl/dma_bus_seq.sv
// Bus sequencing: request, select at grant, own, hand back.
module dma_bus_seq
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           any_elig,
  input  logic [NCH-1:0] pick,
  input  logic           higher_pend,
  input  logic [NCH-1:0] hold_eff,
  input  logic           bus_grant,
  input  logic           unit_done,
  input  logic           last_unit,
  input  logic           ext_master_req,
  output logic           bus_req,
  output logic           owning,
  output logic [NCH-1:0] owner
);
  arb_state_t     st, st_nxt;
  logic [NCH-1:0] own_nxt;
  logic           keeps_bus;
  logic           let_go;

  // The owner keeps the bus only for a held transfer not yet at its end,
  // with nobody of higher rank waiting.
  assign keeps_bus = (|(owner & hold_eff)) & ~last_unit & ~higher_pend & ~ext_master_req;
  assign let_go    = unit_done & ~keeps_bus;

  always_comb begin
    st_nxt  = st;
    own_nxt = owner;
    case (st)
      ST_IDLE: begin
        if (any_elig) st_nxt = ST_REQ;
      end
      ST_REQ: begin
        if (bus_grant) begin
          if (any_elig) begin
            st_nxt  = ST_OWN;
            own_nxt = pick;
          end else begin
            st_nxt = ST_REL;
          end
        end
      end
      ST_OWN: begin
        if (let_go) st_nxt = ST_REL;
      end
      ST_REL: begin
        own_nxt = '0;
        st_nxt  = any_elig ? ST_REQ : ST_IDLE;
      end
      default: begin
        st_nxt  = ST_IDLE;
        own_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      owner <= '0;
    end else begin
      st    <= st_nxt;
      owner <= own_nxt;
    end
  end

  assign bus_req = (st == ST_REQ) || (st == ST_OWN);
  assign owning  = (st == ST_OWN);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dual_mode,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] xfer_hold,
  output logic           bus_req,
  input  logic           bus_grant,
  input  logic           ext_master_req,
  input  logic           unit_done,
  input  logic           last_unit,
  output logic [NCH-1:0] active
);
  logic [NCH-1:0] elig, hold_eff, pick, owner;
  logic           any_elig, higher_pend, owning;

  dma_req_mask #(.NCH(NCH)) u_mask (
    .dual_mode (dual_mode),
    .chan_req  (chan_req),
    .xfer_hold (xfer_hold),
    .elig      (elig),
    .hold_eff  (hold_eff)
  );

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .elig        (elig),
    .owner       (owner),
    .pick        (pick),
    .any_elig    (any_elig),
    .higher_pend (higher_pend)
  );

  dma_bus_seq #(.NCH(NCH)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .any_elig       (any_elig),
    .pick           (pick),
    .higher_pend    (higher_pend),
    .hold_eff       (hold_eff),
    .bus_grant      (bus_grant),
    .unit_done      (unit_done),
    .last_unit      (last_unit),
    .ext_master_req (ext_master_req),
    .bus_req        (bus_req),
    .owning         (owning),
    .owner          (owner)
  );

  assign active = (owning && bus_grant) ? owner : '0;
endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           dual_mode,
  input logic           bus_grant,
  input logic           bus_req,
  input logic           unit_done,
  input logic           ext_master_req,
  input logic [NCH-1:0] active
);
  function automatic logic [NCH-1:0] b_side_mask();
    logic [NCH-1:0] m;
    m = '0;
    for (int i = 1; i < NCH; i += 2) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [NCH-1:0] BMASK = b_side_mask();

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!bus_req && active == '0));

  // R5
  no_grant_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_grant |-> active == '0);

  // R5
  single_owner_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(active));

  // R4
  b_side_never_wins_chk: assert property (@(posedge clk) disable iff (rst)
    dual_mode |-> (active & BMASK) == '0);

  // R6
  owner_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (active != '0 && !unit_done) |=> (active == $past(active) || !bus_grant));

  // R7
  quad_unit_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && unit_done && active != '0) |=> !bus_req);

  // R11
  master_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && ext_master_req && unit_done && active != '0) |=> !bus_req);
endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .dual_mode      (dual_mode),
  .bus_grant      (bus_grant),
  .bus_req        (bus_req),
  .unit_done      (unit_done),
  .ext_master_req (ext_master_req),
  .active         (active)
);

// File: tb/sim_dma_chan_arbiter.sv
module sim_dma_chan_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dual_mode = 1'b0;
  logic [3:0] chan_req = '0;
  logic [3:0] xfer_hold = '0;
  logic       bus_grant = 1'b0;
  logic       ext_master_req = 1'b0;
  logic       unit_done = 1'b0;
  logic       last_unit = 1'b0;
  logic       bus_req;
  logic [3:0] active;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  dma_chan_arbiter #(.NCH(4)) u0 (
    .clk(clk), .rst(rst), .dual_mode(dual_mode), .chan_req(chan_req),
    .xfer_hold(xfer_hold), .bus_req(bus_req), .bus_grant(bus_grant),
    .ext_master_req(ext_master_req), .unit_done(unit_done),
    .last_unit(last_unit), .active(active)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_req(input string tag);
    int waited = 0;
    while (bus_req !== 1'b1 && waited < 8) begin
      step();
      waited++;
    end
    check(tag, {3'b0, bus_req}, 4'b0001);
  endtask

  // Driver: grant the bus and tell the scoreboard which lane must win.
  task automatic take_bus(input logic [3:0] exp, input string tag);
    wait_req(tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_grant = 1'b1;
    step();
  endtask

  task automatic unit(input logic last, input logic exp_rel, input string tag);
    unit_done = 1'b1;
    last_unit = last;
    step();
    unit_done = 1'b0;
    last_unit = 1'b0;
    check(tag, {3'b0, bus_req}, {3'b0, ~exp_rel});
    if (exp_rel) check(tag, active, 4'b0000);
  endtask

  task automatic after_release(input logic [3:0] served, input logic exp_req, input string tag);
    bus_grant = 1'b0;
    chan_req  = chan_req & ~served;
    step();
    check(tag, {3'b0, bus_req}, {3'b0, exp_req});
  endtask

  // Monitor: each new owner is compared against the queued expectation.
  initial begin
    logic [3:0] prev;
    logic [3:0] e;
    string      t;
    prev = '0;
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (!bus_grant && active != '0) check("R5 idle without grant", active, 4'b0000);
        if (active != '0 && prev == '0) begin
          if (exp_q.size() == 0) begin
            check("R3 unexpected owner", active, 4'b0000);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, active, e);
          end
        end
        prev = active;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 reset bus_req", {3'b0, bus_req}, 4'b0000);
    check("R1 reset active", active, 4'b0000);

    // R2: one cycle from request to bus request
    chan_req = 4'b0001;
    step();
    check("R2 bus_req raised", {3'b0, bus_req}, 4'b0001);
    take_bus(4'b0001, "R2 single lane owner");
    unit(1'b0, 1'b1, "R7 unit release");
    after_release(4'b0001, 1'b0, "R12 stays low when empty");

    // R3 and R7: all four lanes, hold ignored in four-lane mode
    xfer_hold = 4'b1111;
    chan_req  = 4'b1111;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] oh;
      oh = 4'b0001 << i;
      take_bus(oh, "R3 fixed rank");
      unit(1'b0, 1'b1, "R7 hold ignored");
      after_release(oh, (i < 3), "R12 re-request");
    end
    xfer_hold = '0;

    // R3: selection uses requests at grant time
    chan_req = 4'b1000;
    step();
    chan_req = 4'b1100;
    take_bus(4'b0100, "R3 grant-time pick");
    unit(1'b0, 1'b1, "R7 unit release");
    after_release(4'b0100, 1'b1, "R12 pending re-request");
    take_bus(4'b1000, "R3 lowest lane");
    chan_req = chan_req | 4'b0001;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R6 owner unchanged", active, 4'b1000);
    end
    unit(1'b0, 1'b1, "R7 unit release");
    after_release(4'b1000, 1'b1, "R12 pending re-request");
    take_bus(4'b0001, "R3 waiting lane served");
    unit(1'b0, 1'b1, "R7 unit release");
    after_release(4'b0001, 1'b0, "R12 empty");

    // R4 and R8: two-lane mode
    step();
    dual_mode = 1'b1;
    chan_req  = 4'b1010;
    repeat (3) step();
    check("R4 B-side ignored", {3'b0, bus_req}, 4'b0000);
    chan_req = 4'b1110;
    take_bus(4'b0100, "R4 channel 1 only eligible");
    unit(1'b0, 1'b1, "R8 per-unit release");
    after_release(4'b0100, 1'b0, "R4 leftover B ignored");
    chan_req = 4'b0101;
    take_bus(4'b0001, "R4 channel 0 over 1");
    unit(1'b0, 1'b1, "R8 per-unit release");
    after_release(4'b0001, 1'b1, "R12 pending re-request");
    take_bus(4'b0100, "R4 channel 1 next");
    unit(1'b0, 1'b1, "R8 per-unit release");
    after_release(4'b0100, 1'b0, "R12 empty");

    // R9: held transfer keeps bus until last unit
    xfer_hold = 4'b0100;
    chan_req  = 4'b0100;
    take_bus(4'b0100, "R9 held owner");
    unit(1'b0, 1'b0, "R9 keep bus");
    check("R9 owner kept", active, 4'b0100);
    unit(1'b0, 1'b0, "R9 keep bus");
    unit(1'b1, 1'b1, "R9 last unit releases");
    after_release(4'b0100, 1'b0, "R12 empty");

    // R10: lower-ranked request does not cut a held transfer
    xfer_hold = 4'b0001;
    chan_req  = 4'b0001;
    take_bus(4'b0001, "R10 held top lane");
    chan_req = 4'b0101;
    unit(1'b0, 1'b0, "R10 lower rank no cut");
    unit(1'b1, 1'b1, "R9 last unit releases");
    after_release(4'b0001, 1'b1, "R12 pending re-request");
    take_bus(4'b0100, "R10 lower lane later");
    unit(1'b0, 1'b1, "R8 per-unit release");
    after_release(4'b0100, 1'b0, "R12 empty");

    // R10: higher-ranked request cuts a held transfer
    xfer_hold = 4'b0100;
    chan_req  = 4'b0100;
    take_bus(4'b0100, "R10 held low lane");
    unit(1'b0, 1'b0, "R9 keep bus");
    chan_req = 4'b0101;
    unit(1'b0, 1'b1, "R10 preempt at unit");
    after_release(4'b0000, 1'b1, "R12 pending re-request");
    take_bus(4'b0001, "R10 higher lane wins");
    unit(1'b0, 1'b1, "R8 per-unit release");
    after_release(4'b0001, 1'b1, "R12 pending re-request");
    take_bus(4'b0100, "R10 cut lane resumes");
    unit(1'b1, 1'b1, "R9 last unit releases");
    after_release(4'b0100, 1'b0, "R12 empty");

    // R11: another bus master cuts a held transfer
    xfer_hold = 4'b0001;
    chan_req  = 4'b0001;
    take_bus(4'b0001, "R11 held owner");
    ext_master_req = 1'b1;
    unit(1'b0, 1'b1, "R11 master preempt");
    ext_master_req = 1'b0;
    after_release(4'b0000, 1'b1, "R12 pending re-request");
    take_bus(4'b0001, "R11 resume");
    unit(1'b1, 1'b1, "R9 last unit releases");
    after_release(4'b0001, 1'b0, "R12 empty");

    repeat (2) step();
    if (exp_q.size() != 0) check("R3 owners missing", 4'(exp_q.size()), 4'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule